// File: doc/BRIEF.md
# Eight-Channel DAC Command Front End

This block is the digital front end of an eight-channel, 12-bit digital-to-analog converter. A host shifts 16-bit words into it, most significant bit first, over a three-wire serial link. The wires are a serial clock, a data line and an active-low frame select. Each completed word is one of two kinds. A data write loads one channel's input register. A control command changes the block's configuration.

The block keeps an input register and an output (DAC) register for each channel. A programmable load policy decides when input registers are copied into the DAC registers. The policy can copy continuously, hold the DAC registers latched, or copy once and then fall back to holding. The block also stores reference and gain settings for two channel groups: channels A to D, and channels E to H. It drives out the group settings as they actually apply, which means the supply-reference select overrides buffering and gain. It also drives one power-down flag per channel.

The serial pins are sampled by the block's own clock through synchronizer flops. A word is accepted only when its frame carries exactly sixteen falling serial-clock edges, and it is decoded when the frame select rises.

Top module: `octdac_cmd_front`

## Requirements
- R1: After reset, all DAC codes and power-down flags are zero. The supply-reference, buffer and gain outputs are zero, and `loadPolicy` reads 01 (latched).
- R2: A word with bit 15 = 0 is a data write. Bits 14:12 give the channel (000 = A … 111 = H) and bits 11:0 give the code. Under the latched policy the write changes only the input register, so the DAC outputs stay unchanged.
- R3: A frame with fewer or more than 16 falling serial-clock edges has no effect on any register.
- R4: A word with bits 15:13 = 101 is a load command. With bits 1:0 = 00 it selects the continuous policy (`loadPolicy` = 00). Under that policy each DAC register takes its input register's value one clock later.
- R5: A load command with bits 1:0 = 10 copies all eight input registers into the DAC registers in one clock cycle. The policy then reads 01, and no further copy happens.
- R6: A load command with bits 1:0 = 11 leaves the policy unchanged. A load command with bits 1:0 = 01 selects the latched policy.
- R7: A word with bits 15:13 = 100 sets the group settings. Bits 1:0 select the supply reference, bits 3:2 select reference buffering and bits 5:4 select 2x gain. The lower bit of each pair is for group A–D and the upper bit is for group E–H.
- R8: For a group whose supply-reference select is set, the effective buffer and gain outputs read 0.
- R9: A word with bits 15:13 = 110 loads the power-down flags from bits 7:0. Bit 0 is channel A and bit 7 is channel H.
- R10: A word with bits 15:13 = 111 clears all input and DAC registers, the group settings and the power-down flags, and sets the latched policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| frameN | input | 1 | Active-low frame select; rising edge ends a word |
| dacCodes | output | NumCh*CodeW | DAC register codes, channel A in the low bits |
| pwrDown | output | NumCh | Per-channel power-down flags, bit 0 = channel A |
| grpVddSel | output | NumGrp | Supply reference selected per group |
| grpBufEff | output | NumGrp | Effective reference buffering per group |
| grpGainEff | output | NumGrp | Effective 2x gain per group |
| loadPolicy | output | 2 | Current load policy: 00 continuous, 01 latched |

## Verification
Data writes go to the first channel, the last channel and a middle channel, so the address decoding is exercised across its whole range. Each write is followed by a one-shot copy, which separates a correct address decode from a stuck or shifted one. The same write is sent under the continuous and the latched policies, which shows whether the DAC register follows the input register or holds its value. Frames of 15 and 17 edges are sent before a valid 16-edge frame, so the edge count rule is tested from both sides. Group settings are sent with the supply-reference select set on one group and then on the other, which exposes any leak of buffer or gain through the override or any swap between groups.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    LD_CONT = 2'b00,
    LD_HOLD = 2'b01,
    LD_ONCE = 2'b10,
    LD_RSVD = 2'b11
  } ldPolicy_e;

  typedef enum logic [1:0] {
    MD_REF  = 2'b00,
    MD_LOAD = 2'b01,
    MD_PWR  = 2'b10,
    MD_RST  = 2'b11
  } cmdMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrData;
    logic setRef;
    logic setPd;
    logic doReset;
    logic copyAll;
  } dpStrobe_t;

endpackage

// File: rtl/octdac_frame_rx.sv
module octdac_frame_rx #(
  parameter int WordW     = 16,
  parameter int SyncDepth = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             frameN,
  output logic             wordValid,
  output logic [WordW-1:0] word
);

  localparam int CntW = $clog2(WordW + 2);
  localparam logic [CntW-1:0] FullCnt = CntW'(WordW);
  localparam logic [CntW-1:0] OverCnt = CntW'(WordW + 1);

  logic [SyncDepth-1:0] clkPipe, datPipe, frmPipe;
  logic clkLast, frmLast;
  logic clkS, datS, frmS;
  logic clkFall, frmRise;
  logic [CntW-1:0] bitCnt;
  logic [WordW-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '1;
      datPipe <= '0;
      frmPipe <= '1;
      clkLast <= 1'b1;
      frmLast <= 1'b1;
    end else begin
      clkPipe <= {clkPipe[SyncDepth-2:0], serClk};
      datPipe <= {datPipe[SyncDepth-2:0], serData};
      frmPipe <= {frmPipe[SyncDepth-2:0], frameN};
      clkLast <= clkS;
      frmLast <= frmS;
    end
  end

  assign clkS    = clkPipe[SyncDepth-1];
  assign datS    = datPipe[SyncDepth-1];
  assign frmS    = frmPipe[SyncDepth-1];
  assign clkFall = clkLast & ~clkS;
  assign frmRise = ~frmLast & frmS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftQ    <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (frmRise) begin
        wordValid <= (bitCnt == FullCnt);
        bitCnt    <= '0;
      end else if (frmS) begin
        bitCnt <= '0;
      end else if (clkFall && bitCnt != OverCnt) begin
        shiftQ <= {shiftQ[WordW-2:0], datS};
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign word = shiftQ;

endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       typeBit,
  input  logic [1:0] modeBits,
  input  logic [1:0] selBits,
  output dpStrobe_t  stb,
  output ldPolicy_e  policy
);

  logic     isCmd;
  logic     oncePend;
  cmdMode_e mode;

  assign isCmd = wordValid & typeBit;
  assign mode  = cmdMode_e'(modeBits);

  always_comb begin
    stb.wrData  = wordValid & ~typeBit;
    stb.setRef  = isCmd && (mode == MD_REF);
    stb.setPd   = isCmd && (mode == MD_PWR);
    stb.doReset = isCmd && (mode == MD_RST);
    stb.copyAll = (policy == LD_CONT) | oncePend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      policy   <= LD_HOLD;
      oncePend <= 1'b0;
    end else begin
      oncePend <= 1'b0;
      if (isCmd && mode == MD_RST) begin
        policy <= LD_HOLD;
      end else if (isCmd && mode == MD_LOAD) begin
        case (ldPolicy_e'(selBits))
          LD_CONT: policy <= LD_CONT;
          LD_HOLD: policy <= LD_HOLD;
          LD_ONCE: begin
            policy   <= LD_HOLD;
            oncePend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/octdac_dpath.sv
module octdac_dpath
  import octdac_pkg::*;
#(
  parameter int NumCh  = 8,
  parameter int CodeW  = 12,
  parameter int NumGrp = 2,
  parameter int PayW   = 15
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic [PayW-1:0]        payload,
  output logic [NumCh*CodeW-1:0] inCodes,
  output logic [NumCh*CodeW-1:0] dacCodes,
  output logic [NumCh-1:0]       pwrDown,
  output logic [NumGrp-1:0]      vddSel,
  output logic [NumGrp-1:0]      bufEff,
  output logic [NumGrp-1:0]      gainEff
);

  localparam int AddrW = $clog2(NumCh);

  logic [AddrW-1:0]  chanSel;
  logic [CodeW-1:0]  codeIn;
  logic [NumGrp-1:0] vddQ, bufQ, gainQ;

  assign chanSel = payload[PayW-1 -: AddrW];
  assign codeIn  = payload[CodeW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vddQ    <= '0;
      bufQ    <= '0;
      gainQ   <= '0;
      pwrDown <= '0;
    end else if (stb.doReset) begin
      vddQ    <= '0;
      bufQ    <= '0;
      gainQ   <= '0;
      pwrDown <= '0;
    end else begin
      if (stb.setRef) begin
        vddQ  <= payload[NumGrp-1:0];
        bufQ  <= payload[2*NumGrp-1:NumGrp];
        gainQ <= payload[3*NumGrp-1:2*NumGrp];
      end
      if (stb.setPd) begin
        pwrDown <= payload[NumCh-1:0];
      end
    end
  end

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_chan
    logic [CodeW-1:0] inQ, dacQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inQ  <= '0;
        dacQ <= '0;
      end else if (stb.doReset) begin
        inQ  <= '0;
        dacQ <= '0;
      end else begin
        if (stb.wrData && chanSel == AddrW'(ch)) inQ <= codeIn;
        if (stb.copyAll) dacQ <= inQ;
      end
    end
    assign inCodes[ch*CodeW +: CodeW]  = inQ;
    assign dacCodes[ch*CodeW +: CodeW] = dacQ;
  end

  for (genvar g = 0; g < NumGrp; g++) begin : g_grp
    assign bufEff[g]  = bufQ[g] & ~vddQ[g];
    assign gainEff[g] = gainQ[g] & ~vddQ[g];
  end

  assign vddSel = vddQ;

endmodule

// File: rtl/octdac_cmd_front.sv
module octdac_cmd_front
  import octdac_pkg::*;
#(
  parameter int NumCh     = 8,
  parameter int CodeW     = 12,
  parameter int NumGrp    = 2,
  parameter int SyncDepth = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   serClk,
  input  logic                   serData,
  input  logic                   frameN,
  output logic [NumCh*CodeW-1:0] dacCodes,
  output logic [NumCh-1:0]       pwrDown,
  output logic [NumGrp-1:0]      grpVddSel,
  output logic [NumGrp-1:0]      grpBufEff,
  output logic [NumGrp-1:0]      grpGainEff,
  output logic [1:0]             loadPolicy
);

  localparam int WordW = WORD_W;
  localparam int PayW  = WordW - 1;

  logic                   rxValid;
  logic [WordW-1:0]       rxWord;
  dpStrobe_t              stb;
  ldPolicy_e              policy;
  logic [NumCh*CodeW-1:0] inCodes;

  octdac_frame_rx #(.WordW(WordW), .SyncDepth(SyncDepth)) u_rx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .frameN(frameN), .wordValid(rxValid), .word(rxWord)
  );

  octdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(rxValid),
    .typeBit(rxWord[WordW-1]), .modeBits(rxWord[WordW-2 -: 2]),
    .selBits(rxWord[1:0]), .stb(stb), .policy(policy)
  );

  octdac_dpath #(.NumCh(NumCh), .CodeW(CodeW), .NumGrp(NumGrp), .PayW(PayW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .payload(rxWord[PayW-1:0]),
    .inCodes(inCodes), .dacCodes(dacCodes), .pwrDown(pwrDown),
    .vddSel(grpVddSel), .bufEff(grpBufEff), .gainEff(grpGainEff)
  );

  assign loadPolicy = policy;

endmodule

// File: rtl/octdac_cmd_front_chk.sv
module octdac_cmd_front_chk
  import octdac_pkg::*;
#(
  parameter int NumCh  = 8,
  parameter int CodeW  = 12,
  parameter int NumGrp = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rxValid,
  input logic [2:0]             hdr,
  input logic [7:0]             lowByte,
  input dpStrobe_t              stb,
  input logic [1:0]             loadPolicy,
  input logic [NumCh*CodeW-1:0] inCodes,
  input logic [NumCh*CodeW-1:0] dacCodes,
  input logic [NumCh-1:0]       pwrDown,
  input logic [NumGrp-1:0]      grpVddSel,
  input logic [NumGrp-1:0]      grpBufEff,
  input logic [NumGrp-1:0]      grpGainEff
);

  logic loadCmd, onceCmd, rsvdCmd;
  assign loadCmd = rxValid && hdr == 3'b101;
  assign onceCmd = loadCmd && lowByte[1:0] == 2'b10;
  assign rsvdCmd = loadCmd && lowByte[1:0] == 2'b11;

  // R2
  latched_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.wrData) && $past(loadPolicy) == 2'b01) |-> $stable(dacCodes));

  // R4
  continuous_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadPolicy) == 2'b00 && !$past(stb.doReset)) |-> dacCodes == $past(inCodes));

  // R5
  once_policy_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(onceCmd) |-> loadPolicy == 2'b01);

  // R5
  once_copies_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(onceCmd, 2) && !$past(stb.doReset)) |-> dacCodes == $past(inCodes));

  // R5
  no_stray_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadPolicy == 2'b01 && !$past(onceCmd)) |-> !stb.copyAll);

  // R6
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rsvdCmd) |-> $stable(loadPolicy));

  // R7
  vdd_select_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.setRef) |-> grpVddSel == $past(lowByte[NumGrp-1:0]));

  // R8
  vdd_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grpVddSel & (grpBufEff | grpGainEff)) == '0);

  // R9
  pd_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.setPd) |-> pwrDown == $past(lowByte[NumCh-1:0]));

  // R10
  reset_cmd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.doReset) |-> (dacCodes == '0 && inCodes == '0 && pwrDown == '0
                            && loadPolicy == 2'b01));

endmodule

bind octdac_cmd_front octdac_cmd_front_chk #(
  .NumCh(NumCh), .CodeW(CodeW), .NumGrp(NumGrp)
) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .hdr(rxWord[15:13]),
  .lowByte(rxWord[7:0]), .stb(stb), .loadPolicy(loadPolicy),
  .inCodes(inCodes), .dacCodes(dacCodes), .pwrDown(pwrDown),
  .grpVddSel(grpVddSel), .grpBufEff(grpBufEff), .grpGainEff(grpGainEff)
);

// File: tb/octdac_cmd_front_bench.sv
module octdac_cmd_front_bench;

  localparam int NC = 8;
  localparam int CW = 12;
  localparam int NG = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic frameN = 1'b1;
  logic [NC*CW-1:0] dacCodes;
  logic [NC-1:0] pwrDown;
  logic [NG-1:0] grpVddSel, grpBufEff, grpGainEff;
  logic [1:0] loadPolicy;

  int nChecks = 0;
  int nErrs = 0;

  always #5 clk = ~clk;

  octdac_cmd_front u_octdac_cmd_front (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .frameN(frameN), .dacCodes(dacCodes), .pwrDown(pwrDown),
    .grpVddSel(grpVddSel), .grpBufEff(grpBufEff), .grpGainEff(grpGainEff),
    .loadPolicy(loadPolicy)
  );

  function automatic logic [CW-1:0] codeOf(input int ch);
    return dacCodes[ch*CW +: CW];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [15:0] w, input int nBits);
    @(negedge clk);
    frameN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      serData = (i < 16) ? w[15-i] : 1'b0;
      repeat (3) @(negedge clk);
      serClk = 1'b0;
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (3) @(negedge clk);
    end
    frameN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    sendFrame(w, 16);
  endtask

  task automatic tReset();
    chk("R1 dac codes", 128'(dacCodes), 128'(0));
    chk("R1 power-down", 128'(pwrDown), 128'(0));
    chk("R1 group settings", 128'({grpVddSel, grpBufEff, grpGainEff}), 128'(0));
    chk("R1 policy latched", 128'(loadPolicy), 128'(2'b01));
  endtask

  task automatic tLatchedAndOnce();
    sendWord(16'h2ABC);            // ch C = ABC
    chk("R2 latched write hidden", 128'(codeOf(2)), 128'(12'h000));
    sendWord(16'hA002);            // one-shot
    chk("R5 one-shot copy", 128'(codeOf(2)), 128'(12'hABC));
    chk("R5 policy back to latched", 128'(loadPolicy), 128'(2'b01));
    sendWord(16'h7123);            // ch H = 123
    chk("R5 no second copy", 128'(codeOf(7)), 128'(12'h000));
  endtask

  task automatic tAddressing();
    sendWord(16'h0001);
    sendWord(16'h7FFF);
    sendWord(16'hA002);
    for (int ch = 0; ch < NC; ch++) begin
      logic [CW-1:0] e;
      e = (ch == 0) ? 12'h001 : (ch == 2) ? 12'hABC : (ch == 7) ? 12'hFFF : 12'h000;
      chk($sformatf("R2 channel %0d address", ch), 128'(codeOf(ch)), 128'(e));
    end
  endtask

  task automatic tContinuous();
    sendWord(16'hA000);
    chk("R4 policy continuous", 128'(loadPolicy), 128'(2'b00));
    sendWord(16'h5555);
    chk("R4 continuous write passes", 128'(codeOf(5)), 128'(12'h555));
    sendWord(16'hA001);
    chk("R6 latched selected", 128'(loadPolicy), 128'(2'b01));
    sendWord(16'h5666);
    chk("R2 latched holds after continuous", 128'(codeOf(5)), 128'(12'h555));
  endtask

  task automatic tReserved();
    sendWord(16'hA003);
    chk("R6 reserved keeps latched", 128'(loadPolicy), 128'(2'b01));
    chk("R6 reserved makes no copy", 128'(codeOf(5)), 128'(12'h555));
    sendWord(16'hA000);
    sendWord(16'hA003);
    chk("R6 reserved keeps continuous", 128'(loadPolicy), 128'(2'b00));
    sendWord(16'hA001);
  endtask

  task automatic tFraming();
    sendFrame(16'h10F0, 15);
    sendFrame(16'h10F0, 17);
    sendWord(16'hA002);
    chk("R3 short and long frames dropped", 128'(codeOf(1)), 128'(12'h000));
    chk("R3 valid frame after bad ones", 128'(codeOf(5)), 128'(12'h666));
    sendFrame(16'hC0FF, 15);
    chk("R3 short control frame dropped", 128'(pwrDown), 128'(8'h00));
    sendWord(16'h10F0);
    sendWord(16'hA002);
    chk("R3 sixteen-edge frame taken", 128'(codeOf(1)), 128'(12'h0F0));
  endtask

  task automatic tRefGain();
    sendWord(16'h803D);
    chk("R7 R8 vdd on group A-D", 128'({grpVddSel, grpBufEff, grpGainEff}),
        128'({2'b01, 2'b10, 2'b10}));
    sendWord(16'h803C);
    chk("R7 buffer and gain both groups", 128'({grpVddSel, grpBufEff, grpGainEff}),
        128'({2'b00, 2'b11, 2'b11}));
    sendWord(16'h803E);
    chk("R8 vdd on group E-H", 128'({grpVddSel, grpBufEff, grpGainEff}),
        128'({2'b10, 2'b01, 2'b01}));
  endtask

  task automatic tPowerDown();
    sendWord(16'hC001);
    chk("R9 channel A flag", 128'(pwrDown), 128'(8'h01));
    sendWord(16'hC081);
    chk("R9 channel H flag", 128'(pwrDown), 128'(8'h81));
    sendWord(16'hC0A5);
    chk("R9 mixed flags", 128'(pwrDown), 128'(8'hA5));
  endtask

  task automatic tResetCmd();
    sendWord(16'hA000);
    sendWord(16'hE000);
    chk("R10 policy latched", 128'(loadPolicy), 128'(2'b01));
    chk("R10 dac codes cleared", 128'(dacCodes), 128'(0));
    chk("R10 flags and groups cleared",
        128'({pwrDown, grpVddSel, grpBufEff, grpGainEff}), 128'(0));
    sendWord(16'h3333);
    chk("R10 latched after reset", 128'(codeOf(3)), 128'(12'h000));
    sendWord(16'hA002);
    chk("R10 new write copied", 128'(codeOf(3)), 128'(12'h333));
    chk("R10 input registers cleared", 128'(codeOf(2)), 128'(12'h000));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    tReset();
    tLatchedAndOnce();
    tAddressing();
    tContinuous();
    tReserved();
    tFraming();
    tRefGain();
    tPowerDown();
    tResetCmd();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule